// File: doc/BRIEF.md
# Line-Locked Horizontal Sync Generator for Embedded-Code Video

The block monitors an 8-bit 4:2:2 component video byte stream that carries one byte per pixel clock. It picks out the four-byte timing reference codes embedded in the stream, which mark the end and the start of active video. From these codes it builds a horizontal sync pulse, an active-video flag and a one-clock line-start strobe. Between the start code and the next end code the stream carries samples in Cb, Y, Cr, Y order. During horizontal blanking it carries the filler values 0x80 and 0x10 in turn.

The sync pulse has no fixed width. Each of its two edges has a nominal position tied to the end-of-active-video code. A 10-bit two's-complement offset moves each edge by whole pixel clocks: positive values move it later, toward the next active region, and negative values move it earlier. A negative offset can reach back past the reference code. The block then places that edge in the line before, using the line length it measured between the last two end codes. The offsets are inputs that are read continuously. The block needs no register interface.

Top module: `hsync_gen_656`

## Requirements
- R1: After reset, `hs`, `active_video` and `line_start` are low. `hs` stays low until the first valid end-of-active-video code has been detected.
- R2: A timing reference code is the byte sequence 0xFF, 0x00, 0x00, XY on consecutive clocks, and XY bit 7 must be 1. If XY bit 4 is 1 the code is end-of-active-video (for example 0x9D). If XY bit 4 is 0 it is start-of-active-video (for example 0x80). A sequence whose XY bit 7 is 0, or whose preamble is broken, is ignored.
- R3: `line_start` is high for exactly one clock: the cycle that follows the clock edge that samples the XY byte of an end-of-active-video code. Call that edge E.
- R4: `active_video` goes high at the edge that samples a start-of-active-video XY byte. It goes low at the edge that samples the next end-of-active-video XY byte.
- R5: With a leading offset N = 0, `hs` rises at edge E+3.
- R6: For a positive leading offset N from 1 (0x001) to 511 (0x1FF), `hs` rises at edge E+3+N.
- R7: For a leading offset N of -1 (0x3FF) or -2 (0x3FE), `hs` rises at edge E+3+N, which lies in the same line.
- R8: For a leading offset N from -3 down to -512 (0x200), `hs` rises at edge E'+3+N, where E' is the next end-code edge. This edge is placed using the line length measured between the previous two end codes. The rise is suppressed until two end codes have been seen since reset.
- R9: The trailing edge uses a second offset M with the same sign convention. `hs` falls at edge E+3+64+M (the nominal width is 64 clocks). When 66+M is negative, `hs` falls at E'+3+64+M, placed in the same way as in R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_in | input | 8 | Embedded-code video byte stream |
| lead_ofs | input | 10 | Signed shift of the sync leading edge, in clocks |
| trail_ofs | input | 10 | Signed shift of the sync trailing edge, in clocks |
| hs | output | 1 | Horizontal sync, active high, registered |
| active_video | output | 1 | High between start and end of active video |
| line_start | output | 1 | One-clock strobe on each end-of-active-video code |

## Verification
The bench exercises leading offsets at 0, +1-class small values, +511, -1, -2, -3 and -512. Together these cover the boundary where an edge leaves its own line and must be placed using the measured length of the previous line. An off-by-one in the nominal point, or a mishandled sign extension, moves the rise by a clock, or by hundreds of clocks at the extremes. A wrap that skips the previous-line length either loses the pulse entirely or puts it a whole line away. Invalid codes, with bit 7 clear or a broken preamble, are fed in; a detector that ignored bit 7 would pulse `line_start`. A fresh reset followed by a wrapping offset checks that no pulse appears before a line length is known.

// File: rtl/hsg_pkg.sv
package hsg_pkg;

    localparam int PIX_W  = 8;
    localparam int OFS_W  = 10;
    localparam int POS_W  = 12;
    localparam int REL_W  = POS_W + 2;

    localparam logic [PIX_W-1:0] PRE_ONES  = 8'hFF;
    localparam logic [PIX_W-1:0] PRE_ZERO  = 8'h00;
    localparam int               FLAG_BIT  = 7;
    localparam int               HBIT      = 4;

    localparam logic [POS_W-1:0] POS_MAX   = '1;
    // Counter index (0 in the strobe cycle) whose match makes hs change
    // three edges after the XY byte is sampled.
    localparam int               LEAD_BASE = 2;

    typedef struct packed {
        logic eav;
        logic sav;
    } trs_hit_t;

    typedef struct packed {
        logic             valid;
        logic [POS_W-1:0] pos;
    } edge_pos_t;

    // Map a signed position relative to the line reference onto the
    // line counter; negative positions fold back by the measured length.
    function automatic edge_pos_t locate_edge(
        input logic signed [REL_W-1:0] rel,
        input logic [POS_W-1:0]        len,
        input logic                    len_ok
    );
        edge_pos_t               r;
        logic signed [REL_W-1:0] w;
        w = rel + $signed({{(REL_W-POS_W){1'b0}}, len});
        if (!rel[REL_W-1]) begin
            r.valid = (rel[REL_W-1:POS_W] == '0);
            r.pos   = rel[POS_W-1:0];
        end else begin
            r.valid = len_ok && (w[REL_W-1:POS_W] == '0);
            r.pos   = w[POS_W-1:0];
        end
        return r;
    endfunction

endpackage

// File: rtl/hsg_trs_detect.sv
module hsg_trs_detect
    import hsg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [PIX_W-1:0] pix_in,
    output trs_hit_t         hit
);

    logic [2:0][PIX_W-1:0] hist;
    logic                  pre_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
        end else begin
            hist <= {hist[1:0], pix_in};
        end
    end

    always_comb begin
        pre_ok  = (hist[2] == PRE_ONES) && (hist[1] == PRE_ZERO) &&
                  (hist[0] == PRE_ZERO) && pix_in[FLAG_BIT];
        hit.eav = pre_ok && pix_in[HBIT];
        hit.sav = pre_ok && !pix_in[HBIT];
    end

endmodule

// File: rtl/hsg_line_timer.sv
module hsg_line_timer
    import hsg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             eav_hit,
    output logic [POS_W-1:0] pos,
    output logic [POS_W-1:0] line_len,
    output logic             seen,
    output logic             len_ok
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos      <= '0;
            line_len <= '0;
            seen     <= 1'b0;
            len_ok   <= 1'b0;
        end else if (eav_hit) begin
            pos      <= '0;
            line_len <= (pos == POS_MAX) ? POS_MAX : pos + 1'b1;
            seen     <= 1'b1;
            len_ok   <= seen;
        end else if (pos != POS_MAX) begin
            pos <= pos + 1'b1;
        end
    end

endmodule

// File: rtl/hsg_edge_locator.sv
module hsg_edge_locator
    import hsg_pkg::*;
#(
    parameter int BASE = 2
) (
    input  logic [OFS_W-1:0] ofs,
    input  logic [POS_W-1:0] line_len,
    input  logic             len_ok,
    output edge_pos_t        edge_pos
);

    localparam logic signed [REL_W-1:0] BASE_V = REL_W'(BASE);

    logic signed [REL_W-1:0] rel;

    always_comb begin
        rel      = BASE_V + $signed({{(REL_W-OFS_W){ofs[OFS_W-1]}}, ofs});
        edge_pos = locate_edge(rel, line_len, len_ok);
    end

endmodule

// File: rtl/hsync_gen_656.sv
module hsync_gen_656
    import hsg_pkg::*;
#(
    parameter int NOM_WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIX_W-1:0] pix_in,
    input  logic [OFS_W-1:0] lead_ofs,
    input  logic [OFS_W-1:0] trail_ofs,
    output logic             hs,
    output logic             active_video,
    output logic             line_start
);

    localparam int TRAIL_BASE = LEAD_BASE + NOM_WIDTH;

    trs_hit_t         hit;
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] line_len;
    logic             seen;
    logic             len_ok;
    edge_pos_t        lead_pos;
    edge_pos_t        trail_pos;
    logic             lead_now;
    logic             trail_now;

    hsg_trs_detect u_detect (
        .clk    (clk),
        .rst    (rst),
        .pix_in (pix_in),
        .hit    (hit)
    );

    hsg_line_timer u_timer (
        .clk      (clk),
        .rst      (rst),
        .eav_hit  (hit.eav),
        .pos      (pos),
        .line_len (line_len),
        .seen     (seen),
        .len_ok   (len_ok)
    );

    hsg_edge_locator #(.BASE(LEAD_BASE)) u_lead (
        .ofs      (lead_ofs),
        .line_len (line_len),
        .len_ok   (len_ok),
        .edge_pos (lead_pos)
    );

    hsg_edge_locator #(.BASE(TRAIL_BASE)) u_trail (
        .ofs      (trail_ofs),
        .line_len (line_len),
        .len_ok   (len_ok),
        .edge_pos (trail_pos)
    );

    assign lead_now  = lead_pos.valid  && (pos == lead_pos.pos);
    assign trail_now = trail_pos.valid && (pos == trail_pos.pos);

    always_ff @(posedge clk) begin
        if (rst) begin
            hs           <= 1'b0;
            active_video <= 1'b0;
            line_start   <= 1'b0;
        end else begin
            line_start <= hit.eav;
            if (hit.sav) begin
                active_video <= 1'b1;
            end else if (hit.eav) begin
                active_video <= 1'b0;
            end
            // Leading edge wins when both edges land on one count.
            if (!seen) begin
                hs <= 1'b0;
            end else if (lead_now) begin
                hs <= 1'b1;
            end else if (trail_now) begin
                hs <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/hsg_checker.sv
module hsg_checker
    import hsg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [PIX_W-1:0] pix_in,
    input logic             hs,
    input logic             active_video,
    input logic             line_start
);

    logic got_line;

    always_ff @(posedge clk) begin
        if (rst) begin
            got_line <= 1'b0;
        end else if (line_start) begin
            got_line <= 1'b1;
        end
    end

    assert_hs_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !got_line |-> !hs);

    assert_code_shape_R2: assert property (@(posedge clk) disable iff (rst)
        line_start |-> ($past(pix_in, 1) & 8'h90) == 8'h90 &&
                       $past(pix_in, 2) == PRE_ZERO &&
                       $past(pix_in, 3) == PRE_ZERO &&
                       $past(pix_in, 4) == PRE_ONES);

    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (rst)
        line_start |=> !line_start);

    assert_active_ends_R4: assert property (@(posedge clk) disable iff (rst)
        line_start |-> !active_video);

    assert_active_src_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(active_video) |-> $past(pix_in[FLAG_BIT]) && !$past(pix_in[HBIT]));

endmodule

bind hsync_gen_656 hsg_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .pix_in       (pix_in),
    .hs           (hs),
    .active_video (active_video),
    .line_start   (line_start)
);

// File: tb/hsync_gen_656_tb_top.sv
`timescale 1ns/1ps
module hsync_gen_656_tb_top;

    localparam int W     = 64;
    localparam int LIMIT = 150000;
    localparam int LOGN  = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pix = 8'h80;
    logic [9:0] lead = '0;
    logic [9:0] trail = '0;
    logic       hs, act, ls;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;

    int rise_log [LOGN];
    int fall_log [LOGN];
    int ls_log   [LOGN];
    int ar_log   [LOGN];
    int af_log   [LOGN];
    int rise_n, fall_n, ls_n, ar_n, af_n, ls_hi;
    int eav_e [16];
    int sav_e [16];
    int line_n;
    logic hs_q = 1'b0, act_q = 1'b0;
    logic fill_tog = 1'b0;

    hsync_gen_656 #(.NOM_WIDTH(W)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .pix_in       (pix),
        .lead_ofs     (lead),
        .trail_ofs    (trail),
        .hs           (hs),
        .active_video (act),
        .line_start   (ls)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (hs && !hs_q && rise_n < LOGN) begin rise_log[rise_n] = cyc; rise_n++; end
        if (!hs && hs_q && fall_n < LOGN) begin fall_log[fall_n] = cyc; fall_n++; end
        if (act && !act_q && ar_n < LOGN) begin ar_log[ar_n] = cyc; ar_n++; end
        if (!act && act_q && af_n < LOGN) begin af_log[af_n] = cyc; af_n++; end
        if (ls) begin
            ls_hi++;
            if (ls_n < LOGN) begin ls_log[ls_n] = cyc; ls_n++; end
        end
        hs_q  = hs;
        act_q = act;
    end

    always @(posedge clk) begin
        if (cyc == LIMIT) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < %0d", cyc, LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(input logic ok, input string req, input int actual, input int expected);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic clear_logs();
        rise_n = 0; fall_n = 0; ls_n = 0; ar_n = 0; af_n = 0; ls_hi = 0; line_n = 0;
    endtask

    function automatic logic rise_at(input int x);
        for (int i = 0; i < rise_n; i++) if (rise_log[i] == x) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic fall_at(input int x);
        for (int i = 0; i < fall_n; i++) if (fall_log[i] == x) return 1'b1;
        return 1'b0;
    endfunction

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        pix = b;
    endtask

    task automatic fill(input int n);
        for (int i = 0; i < n; i++) begin
            put(fill_tog ? 8'h10 : 8'h80);
            fill_tog = ~fill_tog;
        end
    endtask

    // One line of p clocks with a active samples; XY edges are logged.
    task automatic send_line(input int p, input int a);
        logic [7:0] smp [4] = '{8'h60, 8'h50, 8'hA0, 8'h50};
        put(8'hFF); put(8'h00); put(8'h00);
        @(negedge clk); pix = 8'h9D; eav_e[line_n] = cyc + 1;
        fill(p - 8 - a);
        put(8'hFF); put(8'h00); put(8'h00);
        @(negedge clk); pix = 8'h80; sav_e[line_n] = cyc + 1;
        for (int i = 0; i < a; i++) put(smp[i % 4]);
        line_n++;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; pix = 8'h80;
        repeat (4) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        check(hs == 1'b0,  "R1 hs in reset", int'(hs), 0);
        check(act == 1'b0, "R1 active in reset", int'(act), 0);
        check(ls == 1'b0,  "R1 line_start in reset", int'(ls), 0);
        rst = 1'b0;
        clear_logs();
        fill(300);
        check(rise_n == 0, "R1 hs before first code", rise_n, 0);
    endtask

    task automatic t_detect();
        do_reset();
        lead = 10'd0; trail = 10'd0;
        clear_logs();
        put(8'hFF); put(8'h00); put(8'h00); put(8'h1D); fill(20);
        put(8'hFF); put(8'h00); put(8'h00); put(8'h0D); fill(20);
        put(8'hFF); put(8'h00); put(8'h80); put(8'h9D); fill(20);
        check(ls_n == 0, "R2 invalid codes ignored", ls_n, 0);
        check(ar_n == 0, "R2 invalid codes leave active low", ar_n, 0);
        for (int k = 0; k < 3; k++) send_line(300, 200);
        fill(4);
        check(ls_n == 3, "R2 end codes detected", ls_n, 3);
        for (int k = 0; k < 3; k++)
            check(ls_log[k] == eav_e[k], "R3 line_start timing", ls_log[k], eav_e[k]);
        check(ls_hi == 3, "R3 line_start one clock wide", ls_hi, 3);
        check(ar_log[0] == sav_e[0], "R4 active rises at start code", ar_log[0], sav_e[0]);
        check(af_log[0] == eav_e[1], "R4 active falls at end code", af_log[0], eav_e[1]);
        check(rise_at(eav_e[1] + 3), "R5 zero offset rise", rise_n, eav_e[1] + 3);
    endtask

    task automatic t_edges(input int l, input int t, input string lreq, input string treq);
        int el, et;
        lead = l[9:0]; trail = t[9:0];
        clear_logs();
        for (int k = 0; k < 4; k++) send_line(800, 600);
        el = (2 + l >= 0)     ? eav_e[1] + 3 + l     : eav_e[2] + 3 + l;
        et = (2 + W + t >= 0) ? eav_e[1] + 3 + W + t : eav_e[2] + 3 + W + t;
        check(rise_at(el), lreq, (rise_n > 1) ? rise_log[1] : -1, el);
        check(fall_at(et), treq, (fall_n > 1) ? fall_log[1] : -1, et);
    endtask

    task automatic t_no_len();
        int early;
        do_reset();
        lead = 10'h3EC; trail = 10'd0;
        clear_logs();
        for (int k = 0; k < 3; k++) send_line(800, 600);
        early = 0;
        for (int i = 0; i < rise_n; i++) if (rise_log[i] < eav_e[2] - 17) early++;
        check(early == 0, "R8 no wrapped rise before line length known", early, 0);
        check(rise_at(eav_e[2] - 17), "R8 wrapped rise after length known",
              (rise_n > 0) ? rise_log[0] : -1, eav_e[2] - 17);
    endtask

    initial begin
        t_reset();
        t_detect();
        t_edges(0,    0,    "R5 lead 0",      "R9 trail 0");
        t_edges(5,    -3,   "R6 lead +5",     "R9 trail -3");
        t_edges(1,    0,    "R6 lead +1",     "R9 trail 0");
        t_edges(511,  511,  "R6 lead +511",   "R9 trail +511");
        t_edges(-1,   20,   "R7 lead -1",     "R9 trail +20");
        t_edges(-2,   0,    "R7 lead -2",     "R9 trail 0");
        t_edges(-3,   0,    "R8 lead -3",     "R9 trail 0");
        t_edges(-512, -1,   "R8 lead -512",   "R9 trail -1");
        t_edges(0,    -100, "R5 lead 0",      "R9 trail -100 wrapped");
        t_no_len();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule